// File: doc/BRIEF.md
# Remote Terminal Health Word

This block holds the 16-bit self-test and error word of a dual-bus command/response remote terminal. The protocol engine sends it single-cycle strobes: one when it has decoded a command word, with the word's mode flag, mode code and transmit/receive bit, and others for terminal events. These events are transmitter timeouts on each bus, a failed loop-back of the terminal's own transmission, a missed subsystem handshake, word counts that are too high or too low, an illegal broadcast, a bus shutdown and an inhibited terminal flag. The word is presented continuously, so the subsystem can read it and the terminal can report it on the bus.

Each bit has its own rules for setting, clearing and holding. Event bits stay set until the terminal is initialised or receives a legal reset mode command. The two command-legality bits are re-evaluated on every decoded command. The three legal status-reporting mode commands leave the whole word as it was, so the word can be read over the bus without changing it. The mode code values used below are the standard ones: 00010 is transmit status, 01000 is reset terminal, 10010 is transmit last command, 10011 is transmit this word, and 00011 is initiate self-test. The self-test range result arrives as its own strobe.

Top module: `rt_health_word`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the word is cleared, so it reads 0x0000 after reset.
- R2: Bits 15, 14 and 10 always read zero.
- R3: A legal reset command clears every bit. Legal reset means `cmd_valid` with `cmd_mode`=1, `cmd_code`=01000, `cmd_tr`=1 and `ss_cmd_legal`=1.
- R4: A legal status-reporting command leaves every bit unchanged. These are mode codes 00010, 10010 and 10011, with `cmd_tr`=1 and `ss_cmd_legal`=1.
- R5: Any other decoded command (`cmd_valid`=1) clears bit 3 (wrong T/R) and bit 4 (illegal command) before the new flags are applied.
- R6: Bit 3 sets when a decoded mode command has the wrong T/R bit. Codes 0–8, 16, 18 and 19 require `cmd_tr`=1. Codes 17, 20 and 21 require `cmd_tr`=0. All other codes are reserved and are not checked for T/R.
- R7: Bit 4 sets in any of three cases: a decoded command arrives with `ss_cmd_legal`=0; a reserved mode code arrives with `ss_allow_rsvd`=1; or `ev_shutdown_bad` pulses.
- R8: A timeout pulse on bus n sets bit 12+n and bit 0. `ev_selftest_bad` sets bit 0.
- R9: `ev_loop_err` sets bit 2 and `ev_hsk_miss` sets bit 1.
- R10: `ev_wc_low` sets bit 5, `ev_wc_high` sets bit 6, `ev_bcast_bad` sets bit 7, a shutdown of bus n sets bit 8+n, and `ev_flag_inhibit` sets bit 11.
- R11: When a bit is set and cleared in the same cycle, the set wins. A set bit stays set until one of its clear rules applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low initialisation |
| cmd_valid | input | 1 | One-cycle pulse: a valid command word was decoded |
| cmd_mode | input | 1 | The decoded command is a mode command |
| cmd_code | input | 5 | Mode code field |
| cmd_tr | input | 1 | T/R bit of the command (1 = transmit) |
| ss_cmd_legal | input | 1 | Subsystem legality input, sampled with the command; low marks it illegal |
| ss_allow_rsvd | input | 1 | High makes reserved mode codes illegal |
| ev_tx_timeout | input | 2 | Transmitter timeout pulse, one per bus |
| ev_selftest_bad | input | 1 | Self-test found the timeout outside its allowed window |
| ev_loop_err | input | 1 | Loop-back check of own transmission failed |
| ev_hsk_miss | input | 1 | Subsystem missed a data-transfer acknowledge |
| ev_wc_high | input | 1 | Too many data words received |
| ev_wc_low | input | 1 | Too few data words received |
| ev_bcast_bad | input | 1 | Illegal broadcast command |
| ev_bus_off | input | 2 | Bus transmitter shut down, one per bus |
| ev_flag_inhibit | input | 1 | Terminal flag was inhibited |
| ev_shutdown_bad | input | 1 | Illegal transmitter-shutdown mode command |
| health_word | output | 16 | Current word |

## Verification
The bench first sets each event bit in turn. It then applies each command class on top of a word that is already populated, because only a non-zero word can separate "leave untouched" from "clear" and "clear only bits 3 and 4". Wrong T/R is tried on both a transmit-only code and a receive-only code, and on a reserved code with the reserved-code input in each state. This separates the T/R rule from the reserved-code rule. A randomised phase then mixes commands and strobes in the same cycle, against a behavioural model compared on every clock, to find errors in set-over-clear priority.

// File: rtl/rt_hw_pkg.sv
// Package: bit positions, mode codes and helper types for the terminal
// health word. Assumes the standard command/response mode code numbering.
package rt_hw_pkg;

    localparam int unsigned HW_W        = 16;
    localparam int unsigned CODE_W      = 5;

    // Bit positions; software and the bus reader decode these.
    localparam int unsigned POS_TXTO    = 0;
    localparam int unsigned POS_HSK     = 1;
    localparam int unsigned POS_LOOP    = 2;
    localparam int unsigned POS_BADTR   = 3;
    localparam int unsigned POS_BADCMD  = 4;
    localparam int unsigned POS_WCLO    = 5;
    localparam int unsigned POS_WCHI    = 6;
    localparam int unsigned POS_BCAST   = 7;
    localparam int unsigned POS_OFF0    = 8;
    localparam int unsigned POS_INHIBIT = 11;
    localparam int unsigned POS_TO0     = 12;

    // Bits that are never implemented (read zero).
    localparam logic [HW_W-1:0] RSVD_MASK = 16'hC400;

    localparam logic [CODE_W-1:0] MC_TX_STATUS  = 5'b00010;
    localparam logic [CODE_W-1:0] MC_RESET      = 5'b01000;
    localparam logic [CODE_W-1:0] MC_TX_LASTCMD = 5'b10010;
    localparam logic [CODE_W-1:0] MC_TX_BITWORD = 5'b10011;

    typedef enum logic [1:0] {
        TR_FREE = 2'd0,   // reserved code, no T/R rule
        TR_XMIT = 2'd1,   // must carry T/R = 1
        TR_RECV = 2'd2    // must carry T/R = 0
    } tr_rule_e;

    typedef struct packed {
        logic clr_all;
        logic clr_cmd;
        logic set_badtr;
        logic set_badcmd;
    } cmd_eff_t;

    // Required T/R direction for each mode code.
    function automatic tr_rule_e mode_tr_rule(input logic [CODE_W-1:0] code);
        tr_rule_e r;
        if (code <= 5'd8)
            r = TR_XMIT;
        else if (code == 5'd16 || code == 5'd18 || code == 5'd19)
            r = TR_XMIT;
        else if (code == 5'd17 || code == 5'd20 || code == 5'd21)
            r = TR_RECV;
        else
            r = TR_FREE;
        return r;
    endfunction

endpackage

// File: rtl/rt_hw_cmd_decode.sv
// Module: classifies a decoded command into its effects on the health word.
// Assumes all inputs are valid in the cycle cmd_valid is high. Purely
// combinational.
module rt_hw_cmd_decode
    import rt_hw_pkg::*;
(
    input  logic              cmd_valid,
    input  logic              cmd_mode,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              cmd_tr,
    input  logic              ss_cmd_legal,
    input  logic              ss_allow_rsvd,
    output cmd_eff_t          eff
);

    tr_rule_e rule;
    logic     tr_wrong;
    logic     rsvd_hit;
    logic     is_legal;
    logic     is_report;
    logic     is_reset;

    // Legality of the command against T/R rule, reserved codes and subsystem.
    always_comb begin
        rule      = mode_tr_rule(cmd_code);
        tr_wrong  = cmd_mode && (((rule == TR_XMIT) && !cmd_tr) ||
                                 ((rule == TR_RECV) &&  cmd_tr));
        rsvd_hit  = cmd_mode && (rule == TR_FREE) && ss_allow_rsvd;
        is_legal  = ss_cmd_legal && !tr_wrong && !rsvd_hit;
    end

    // Identify status-reporting and reset commands that are legal.
    always_comb begin
        is_report = cmd_mode && is_legal &&
                    ((cmd_code == MC_TX_STATUS) ||
                     (cmd_code == MC_TX_LASTCMD) ||
                     (cmd_code == MC_TX_BITWORD));
        is_reset  = cmd_mode && is_legal && (cmd_code == MC_RESET);
    end

    // Map the classification to set and clear effects.
    always_comb begin
        eff.clr_all    = cmd_valid && is_reset;
        eff.clr_cmd    = cmd_valid && !is_report;
        eff.set_badtr  = cmd_valid && tr_wrong;
        eff.set_badcmd = cmd_valid && (!ss_cmd_legal || rsvd_hit);
    end

endmodule

// File: rtl/rt_hw_event_map.sv
// Module: maps terminal event strobes onto per-bit set requests.
// Assumes one timeout and one shutdown strobe per bus. Combinational.
module rt_hw_event_map
    import rt_hw_pkg::*;
#(
    parameter int unsigned NUM_BUS = 2
) (
    input  logic [NUM_BUS-1:0] ev_tx_timeout,
    input  logic               ev_selftest_bad,
    input  logic               ev_loop_err,
    input  logic               ev_hsk_miss,
    input  logic               ev_wc_high,
    input  logic               ev_wc_low,
    input  logic               ev_bcast_bad,
    input  logic [NUM_BUS-1:0] ev_bus_off,
    input  logic               ev_flag_inhibit,
    input  logic               ev_shutdown_bad,
    output logic [HW_W-1:0]    set_vec
);

    logic [HW_W-1:0] bus_part [NUM_BUS];
    logic [HW_W-1:0] bus_or;

    // Per-bus set requests: timeout bit, shutdown bit.
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        always_comb begin
            bus_part[b] = '0;
            bus_part[b][POS_TO0 + b]  = ev_tx_timeout[b];
            bus_part[b][POS_OFF0 + b] = ev_bus_off[b];
        end
    end

    // OR the per-bus requests together.
    always_comb begin
        bus_or = '0;
        for (int b = 0; b < NUM_BUS; b++)
            bus_or = bus_or | bus_part[b];
    end

    // Single-bit events, including the summary timeout bit.
    always_comb begin
        set_vec                = bus_or;
        set_vec[POS_TXTO]      = (|ev_tx_timeout) || ev_selftest_bad;
        set_vec[POS_HSK]       = ev_hsk_miss;
        set_vec[POS_LOOP]      = ev_loop_err;
        set_vec[POS_BADCMD]    = ev_shutdown_bad;
        set_vec[POS_WCLO]      = ev_wc_low;
        set_vec[POS_WCHI]      = ev_wc_high;
        set_vec[POS_BCAST]     = ev_bcast_bad;
        set_vec[POS_INHIBIT]   = ev_flag_inhibit;
    end

endmodule

// File: rtl/rt_hw_cell.sv
// Module: one sticky bit with set priority over clear. An unimplemented
// cell is tied to zero. Assumes synchronous active-low reset.
module rt_hw_cell #(
    parameter bit IMPLEMENTED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    if (IMPLEMENTED) begin : g_live
        logic q_r;
        // Hold, clear or set the bit; set wins.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_r <= 1'b0;
            else if (set_i)
                q_r <= 1'b1;
            else if (clr_i)
                q_r <= 1'b0;
        end
        assign q = q_r;
    end else begin : g_tied
        logic unused_in;
        assign unused_in = set_i ^ clr_i ^ clk ^ rst_n;
        assign q = 1'b0;
    end

endmodule

// File: rtl/rt_health_word.sv
// Module: top of the remote terminal health word. Combines command effects
// and event strobes into per-bit set/clear requests and keeps the 16 cells.
// Assumes all strobes are single-cycle and synchronous to clk.
module rt_health_word
    import rt_hw_pkg::*;
#(
    parameter int unsigned NUM_BUS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_mode,
    input  logic [4:0]         cmd_code,
    input  logic               cmd_tr,
    input  logic               ss_cmd_legal,
    input  logic               ss_allow_rsvd,
    input  logic [NUM_BUS-1:0] ev_tx_timeout,
    input  logic               ev_selftest_bad,
    input  logic               ev_loop_err,
    input  logic               ev_hsk_miss,
    input  logic               ev_wc_high,
    input  logic               ev_wc_low,
    input  logic               ev_bcast_bad,
    input  logic [NUM_BUS-1:0] ev_bus_off,
    input  logic               ev_flag_inhibit,
    input  logic               ev_shutdown_bad,
    output logic [15:0]        health_word
);

    localparam logic [HW_W-1:0] CMD_BITS =
        (HW_W'(1) << POS_BADTR) | (HW_W'(1) << POS_BADCMD);

    cmd_eff_t        eff;
    logic [HW_W-1:0] ev_set;
    logic [HW_W-1:0] set_vec;
    logic [HW_W-1:0] clr_vec;
    logic [HW_W-1:0] word_q;

    rt_hw_cmd_decode u_dec (
        .cmd_valid     (cmd_valid),
        .cmd_mode      (cmd_mode),
        .cmd_code      (cmd_code),
        .cmd_tr        (cmd_tr),
        .ss_cmd_legal  (ss_cmd_legal),
        .ss_allow_rsvd (ss_allow_rsvd),
        .eff           (eff)
    );

    rt_hw_event_map #(.NUM_BUS(NUM_BUS)) u_map (
        .ev_tx_timeout   (ev_tx_timeout),
        .ev_selftest_bad (ev_selftest_bad),
        .ev_loop_err     (ev_loop_err),
        .ev_hsk_miss     (ev_hsk_miss),
        .ev_wc_high      (ev_wc_high),
        .ev_wc_low       (ev_wc_low),
        .ev_bcast_bad    (ev_bcast_bad),
        .ev_bus_off      (ev_bus_off),
        .ev_flag_inhibit (ev_flag_inhibit),
        .ev_shutdown_bad (ev_shutdown_bad),
        .set_vec         (ev_set)
    );

    // Merge command-driven sets into the event sets.
    always_comb begin
        set_vec             = ev_set;
        set_vec[POS_BADTR]  = ev_set[POS_BADTR]  || eff.set_badtr;
        set_vec[POS_BADCMD] = ev_set[POS_BADCMD] || eff.set_badcmd;
    end

    // Clear requests: reset clears all, other commands clear the legality bits.
    always_comb begin
        clr_vec = {HW_W{eff.clr_all}} | (CMD_BITS & {HW_W{eff.clr_cmd}});
    end

    for (genvar i = 0; i < HW_W; i++) begin : g_cell
        rt_hw_cell #(.IMPLEMENTED(!RSVD_MASK[i])) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .q     (word_q[i])
        );
    end

    assign health_word = word_q;

endmodule

// File: rtl/rt_health_word_chk.sv
// Module: assertion checker bound to rt_health_word; observes ports only.
module rt_health_word_chk #(
    parameter int unsigned NUM_BUS = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               cmd_mode,
    input logic [4:0]         cmd_code,
    input logic               cmd_tr,
    input logic               ss_cmd_legal,
    input logic               ss_allow_rsvd,
    input logic [NUM_BUS-1:0] ev_tx_timeout,
    input logic               ev_selftest_bad,
    input logic               ev_loop_err,
    input logic               ev_hsk_miss,
    input logic               ev_wc_high,
    input logic               ev_wc_low,
    input logic               ev_bcast_bad,
    input logic [NUM_BUS-1:0] ev_bus_off,
    input logic               ev_flag_inhibit,
    input logic               ev_shutdown_bad,
    input logic [15:0]        health_word
);

    logic quiet;
    logic legal_ctl;
    logic rpt_cmd;
    logic rst_cmd;

    // Classify the current cycle from the port values.
    always_comb begin
        quiet = !(|ev_tx_timeout) && !ev_selftest_bad && !ev_loop_err &&
                !ev_hsk_miss && !ev_wc_high && !ev_wc_low && !ev_bcast_bad &&
                !(|ev_bus_off) && !ev_flag_inhibit && !ev_shutdown_bad;
        legal_ctl = cmd_valid && cmd_mode && cmd_tr && ss_cmd_legal;
        rpt_cmd = legal_ctl && (cmd_code == 5'd2 || cmd_code == 5'd18 ||
                                cmd_code == 5'd19);
        rst_cmd = legal_ctl && (cmd_code == 5'd8);
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        health_word[15:14] == 2'b00 && !health_word[10]);

    // R4
    report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_cmd && quiet) |=> $stable(health_word));

    // R3
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_cmd && quiet) |=> health_word == 16'h0000);

    // R9
    loop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_loop_err |=> health_word[2]);

    // R8
    timeout_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_timeout[0] |=> (health_word[12] && health_word[0]));

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (health_word[5] && !rst_cmd) |=> health_word[5]);

endmodule

bind rt_health_word rt_health_word_chk #(.NUM_BUS(NUM_BUS)) u_chk (.*);

// File: tb/rt_health_word_tb.sv
// Bench: directed and randomised stimulus, compared every clock against a
// behavioural model of the requirements.
module rt_health_word_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_mode, cmd_tr, ss_cmd_legal, ss_allow_rsvd;
    logic [4:0]  cmd_code;
    logic [1:0]  ev_tx_timeout, ev_bus_off;
    logic        ev_selftest_bad, ev_loop_err, ev_hsk_miss, ev_wc_high;
    logic        ev_wc_low, ev_bcast_bad, ev_flag_inhibit, ev_shutdown_bad;
    logic [15:0] health_word;

    logic [15:0] model;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 0;

    always #5 clk = ~clk;

    rt_health_word u_dut (.*);

    task automatic idle();
        cmd_valid = 0; cmd_mode = 0; cmd_code = '0; cmd_tr = 0;
        ss_cmd_legal = 1; ss_allow_rsvd = 0;
        ev_tx_timeout = '0; ev_bus_off = '0; ev_selftest_bad = 0;
        ev_loop_err = 0; ev_hsk_miss = 0; ev_wc_high = 0; ev_wc_low = 0;
        ev_bcast_bad = 0; ev_flag_inhibit = 0; ev_shutdown_bad = 0;
    endtask

    // Model update from the requirements, applied at a clock edge.
    task automatic model_edge();
        int  c;
        bit  want_tx, want_rx, reserved, wrong_tr, rsvd_bad, legal;
        bit  report, reset_cmd;
        logic [15:0] nxt;
        if (!rst_n) begin
            model = 16'h0000;       // R1
            return;
        end
        c        = int'(cmd_code);
        want_tx  = (c <= 8) || c == 16 || c == 18 || c == 19;
        want_rx  = c == 17 || c == 20 || c == 21;
        reserved = !want_tx && !want_rx;
        wrong_tr = cmd_mode && ((want_tx && !cmd_tr) || (want_rx && cmd_tr));
        rsvd_bad = cmd_mode && reserved && ss_allow_rsvd;
        legal    = ss_cmd_legal && !wrong_tr && !rsvd_bad;
        report   = cmd_mode && legal && (c == 2 || c == 18 || c == 19);
        reset_cmd = cmd_mode && legal && c == 8;
        nxt = model;
        if (cmd_valid && reset_cmd) nxt = 16'h0000;                    // R3
        if (cmd_valid && !report)   nxt = nxt & ~16'h0018;             // R5
        if (cmd_valid && wrong_tr)  nxt[3] = 1;                        // R6
        if ((cmd_valid && (!ss_cmd_legal || rsvd_bad)) || ev_shutdown_bad)
            nxt[4] = 1;                                                // R7
        if (ev_tx_timeout[0]) begin nxt[12] = 1; nxt[0] = 1; end       // R8
        if (ev_tx_timeout[1]) begin nxt[13] = 1; nxt[0] = 1; end
        if (ev_selftest_bad) nxt[0] = 1;
        if (ev_loop_err) nxt[2] = 1;                                   // R9
        if (ev_hsk_miss) nxt[1] = 1;
        if (ev_wc_low)   nxt[5] = 1;                                   // R10
        if (ev_wc_high)  nxt[6] = 1;
        if (ev_bcast_bad) nxt[7] = 1;
        if (ev_bus_off[0]) nxt[8] = 1;
        if (ev_bus_off[1]) nxt[9] = 1;
        if (ev_flag_inhibit) nxt[11] = 1;
        model = nxt;
    endtask

    task automatic check(input string tag, input logic [15:0] exp);
        n_chk++;
        if (health_word !== exp) begin
            n_bad++;
            $display("FAIL %s: health_word=%h expected %h", tag, health_word, exp);
        end
    endtask

    // One clock: edge, model, then compare at the falling edge; inputs idled.
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, model);
        if (health_word[15:14] != 2'b00 || health_word[10]) begin
            n_bad++;
            $display("FAIL R2: reserved bits %h expected 0", health_word & 16'hC400);
        end
        idle();
    endtask

    task automatic cmd(input bit md, input int code, input bit tr);
        cmd_valid = 1; cmd_mode = md; cmd_code = 5'(code); cmd_tr = tr;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        idle();
        rst_n = 0;
        model = 16'h0000;
        repeat (3) @(negedge clk);
        step("R1");
        check("R1 reset value", 16'h0000);
        rst_n = 1;

        ev_loop_err = 1;       step("R9 loop");      check("R9", 16'h0004);
        ev_hsk_miss = 1;       step("R9 handshake"); check("R9", 16'h0006);
        ev_tx_timeout = 2'b10; step("R8 bus1");      check("R8", 16'h2007);
        ev_selftest_bad = 1;   step("R8 selftest");
        ev_wc_high = 1; ev_wc_low = 1; ev_bcast_bad = 1;
        ev_bus_off = 2'b11; ev_flag_inhibit = 1;
        step("R10");           check("R10", 16'h2BE7);
        ev_tx_timeout = 2'b01; step("R8 bus0");      check("R8", 16'h3BE7);

        cmd(0, 0, 0); ss_cmd_legal = 0; step("R7 subsystem"); check("R7", 16'h3BF7);
        cmd(1, 2, 1);  step("R4 status");  check("R4", 16'h3BF7);
        cmd(1, 18, 1); step("R4 lastcmd"); check("R4", 16'h3BF7);
        cmd(1, 19, 1); step("R4 word");    check("R4", 16'h3BF7);
        cmd(1, 2, 0);  step("R6 xmit rule"); check("R6", 16'h3BEF);
        cmd(0, 5, 0);  step("R5 plain");   check("R5", 16'h3BE7);
        cmd(1, 9, 1); ss_allow_rsvd = 1; step("R7 reserved"); check("R7", 16'h3BF7);
        cmd(1, 9, 0);  step("R6 reserved exempt"); check("R5", 16'h3BE7);
        ev_shutdown_bad = 1; step("R7 shutdown"); check("R7", 16'h3BF7);
        cmd(1, 17, 1); step("R6 recv rule"); check("R6", 16'h3BEF);
        cmd(0, 1, 1); ev_shutdown_bad = 1; step("R11 set wins"); check("R11", 16'h3BF7);
        cmd(1, 8, 1); ev_hsk_miss = 1; step("R11 reset+set"); check("R3", 16'h0002);
        cmd(1, 8, 1);  step("R3 reset");   check("R3", 16'h0000);
        ev_wc_low = 1; step("R10 wc low"); step("R11 hold"); check("R11", 16'h0020);

        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                cmd($urandom_range(0, 3) != 0, int'($urandom_range(0, 31)),
                    $urandom_range(0, 1) == 1);
                ss_cmd_legal  = $urandom_range(0, 5) != 0;
                ss_allow_rsvd = $urandom_range(0, 1) == 1;
            end
            ev_tx_timeout   = 2'($urandom_range(0, 31) == 0 ? $urandom_range(1, 3) : 0);
            ev_bus_off      = 2'($urandom_range(0, 31) == 0 ? $urandom_range(1, 3) : 0);
            ev_selftest_bad = $urandom_range(0, 31) == 0;
            ev_loop_err     = $urandom_range(0, 31) == 0;
            ev_hsk_miss     = $urandom_range(0, 31) == 0;
            ev_wc_high      = $urandom_range(0, 31) == 0;
            ev_wc_low       = $urandom_range(0, 31) == 0;
            ev_bcast_bad    = $urandom_range(0, 31) == 0;
            ev_flag_inhibit = $urandom_range(0, 31) == 0;
            ev_shutdown_bad = $urandom_range(0, 15) == 0;
            rst_n           = $urandom_range(0, 499) != 0;
            step("R11 random");
            rst_n = 1;
        end
        finish_run();
    end

endmodule